// File: doc/BRIEF.md
# Midpoint-Sampling Slow-to-Fast Data Crossing

This block carries a multi-bit word from a slow clock domain into a much faster one. The word itself never passes through synchronizer flops. Only the slow side's qualifying enable crosses, through a short flop chain in the fast domain. When the block sees that enable rise, it starts a small counter. When the counter reaches a programmed value, the block takes one snapshot of the word. The value is chosen from the fast-to-slow frequency ratio so that the snapshot falls near the middle of the enable-high period. By then the word has been stable for many fast cycles, so sampling it directly is safe.

The block emits the snapshot together with a one-cycle valid pulse and holds the word until the next capture. It suits links whose fast clock is many times faster than the slow one. Closely matched clocks call for capturing on the synchronized edge itself, and that case is not handled here.

Top module: `msmp_sampler`

## Requirements
- R1: While `fast_rst` is high at a rising `fast_clk` edge, `fast_data` becomes zero and `fast_valid` becomes low. After reset, no capture happens until the first rising edge of `slow_en` has been detected.
- R2: `slow_en` is sampled through a chain of `SYNC_STAGES` (default 3) fast-domain flops. A rising edge is detected when the second-to-last stage is high and the last stage is low. `slow_data` is never synchronized.
- R3: Each detected rising edge restarts the window counter from zero in the next cycle.
- R4: Between edges, the counter increments by one per fast cycle. It saturates at all-ones (63 for a 6-bit counter) and never wraps. An enable held high for any length therefore yields exactly one capture.
- R5: In the cycle when the counter equals `CAPTURE_AT` (default 33), the next edge loads `slow_data` into `fast_data` and raises `fast_valid`.
- R6: `fast_valid` is high for exactly one fast cycle per capture, and there is exactly one pulse per enable rising edge.
- R7: Between captures, `fast_data` holds its value, even if `slow_data` changes.
- R8: With a ratio large enough, the captured word is the one driven during that enable window, and the pulse arrives while the enable is still high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| fast_clk | input | 1 | Fast destination clock |
| fast_rst | input | 1 | Synchronous active-high reset, fast domain |
| slow_data | input | DATA_W | Word from the slow domain, stable while enabled |
| slow_en | input | 1 | Slow-domain enable qualifying `slow_data` |
| fast_data | output | DATA_W | Captured word, held between captures |
| fast_valid | output | 1 | One-cycle pulse marking a new capture |

## Verification
The bench builds the block with its default parameters: an 8-bit word, three sync stages, a 6-bit counter and a capture count of 33. The fast clock period is 10 ns and the slow-domain drive period is 700 ns, a ratio of 70. Under this ratio the capture count falls about halfway into a one-period enable window. Enables held for three slow periods (210 fast cycles) drive the counter well past saturation, so any wrap would produce a second pulse. Gaps of a single slow period exercise back-to-back restarts. Changing `slow_data` during each gap exercises the hold behaviour.

// File: rtl/msmp_pkg.sv
`timescale 1ns/1ps
package msmp_pkg;

    localparam int DEF_DATA_W     = 8;
    localparam int DEF_SYNC_STAGE = 3;
    localparam int DEF_CNT_W      = 6;
    localparam int DEF_CAPTURE_AT = 33;

    // Largest value a counter of the given width can hold.
    function automatic int sat_of(input int width);
        return (1 << width) - 1;
    endfunction

    // Edge seen when the newer stage is high and the older one still low.
    function automatic logic rise_of(input logic newer, input logic older);
        return newer & ~older;
    endfunction

    typedef enum logic [1:0] {
        WIN_IDLE  = 2'd0,
        WIN_COUNT = 2'd1,
        WIN_DONE  = 2'd2
    } win_phase_e;

endpackage

// File: rtl/msmp_en_sync.sv
`timescale 1ns/1ps
module msmp_en_sync
    import msmp_pkg::*;
#(
    parameter int STAGES = DEF_SYNC_STAGE
) (
    input  logic clk,
    input  logic rst,
    input  logic async_en,
    output logic en_rise
);

    if (STAGES < 3) begin : g_bad_stages
        $error("msmp_en_sync needs at least three stages");
    end

    logic [STAGES-1:0] stg;

    always_ff @(posedge clk) begin
        if (rst) stg <= '0;
        else     stg <= {stg[STAGES-2:0], async_en};
    end

    assign en_rise = rise_of(stg[STAGES-2], stg[STAGES-1]);

    // An edge cannot be reported on two consecutive cycles.
    a_r2_single_edge: assert property (@(posedge clk) disable iff (rst)
        en_rise |=> !en_rise);

endmodule

// File: rtl/msmp_window_cnt.sv
`timescale 1ns/1ps
module msmp_window_cnt
    import msmp_pkg::*;
#(
    parameter int CNT_W      = DEF_CNT_W,
    parameter int CAPTURE_AT = DEF_CAPTURE_AT
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    output logic [CNT_W-1:0] count,
    output logic             hit
);

    localparam int               SAT_INT = sat_of(CNT_W);
    localparam logic [CNT_W-1:0] SAT     = CNT_W'(SAT_INT);
    localparam logic [CNT_W-1:0] TARGET  = CNT_W'(CAPTURE_AT);

    if (CAPTURE_AT >= SAT_INT) begin : g_bad_target
        $error("CAPTURE_AT must be below the counter saturation value");
    end

    win_phase_e phase;

    always_comb begin
        if (count == SAT)          phase = WIN_IDLE;
        else if (count > TARGET)   phase = WIN_DONE;
        else                       phase = WIN_COUNT;
    end

    always_ff @(posedge clk) begin
        if (rst)                 count <= SAT;
        else if (restart)        count <= '0;
        else if (phase != WIN_IDLE) count <= count + 1'b1;
    end

    assign hit = (phase == WIN_COUNT) && (count == TARGET);

    a_r3_restart_zero: assert property (@(posedge clk) disable iff (rst)
        restart |=> (count == '0));

    a_r4_step_up: assert property (@(posedge clk) disable iff (rst)
        (!restart && count != SAT) |=> (count == $past(count) + 1'b1));

    a_r4_no_wrap: assert property (@(posedge clk) disable iff (rst)
        (!restart && count == SAT) |=> (count == SAT));

endmodule

// File: rtl/msmp_capture.sv
`timescale 1ns/1ps
module msmp_capture
    import msmp_pkg::*;
#(
    parameter int DATA_W = DEF_DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              take,
    input  logic [DATA_W-1:0] word_in,
    output logic [DATA_W-1:0] word_out,
    output logic              word_valid
);

    typedef struct packed {
        logic [DATA_W-1:0] word;
        logic              valid;
    } cap_t;

    cap_t q;

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            q.valid <= take;
            if (take) q.word <= word_in;
        end
    end

    assign word_out   = q.word;
    assign word_valid = q.valid;

    a_r5_load_on_hit: assert property (@(posedge clk) disable iff (rst)
        take |=> (word_valid && word_out == $past(word_in)));

    a_r7_hold_word: assert property (@(posedge clk) disable iff (rst)
        !take |=> $stable(word_out));

    a_r6_one_cycle: assert property (@(posedge clk) disable iff (rst)
        word_valid |=> !word_valid);

endmodule

// File: rtl/msmp_sampler.sv
`timescale 1ns/1ps
module msmp_sampler
    import msmp_pkg::*;
#(
    parameter int DATA_W      = DEF_DATA_W,
    parameter int SYNC_STAGES = DEF_SYNC_STAGE,
    parameter int CNT_W       = DEF_CNT_W,
    parameter int CAPTURE_AT  = DEF_CAPTURE_AT
) (
    input  logic              fast_clk,
    input  logic              fast_rst,
    input  logic [DATA_W-1:0] slow_data,
    input  logic              slow_en,
    output logic [DATA_W-1:0] fast_data,
    output logic              fast_valid
);

    logic             en_rise;
    logic [CNT_W-1:0] win_count;
    logic             win_hit;

    msmp_en_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (fast_clk),
        .rst      (fast_rst),
        .async_en (slow_en),
        .en_rise  (en_rise)
    );

    msmp_window_cnt #(.CNT_W(CNT_W), .CAPTURE_AT(CAPTURE_AT)) u_cnt (
        .clk     (fast_clk),
        .rst     (fast_rst),
        .restart (en_rise),
        .count   (win_count),
        .hit     (win_hit)
    );

    msmp_capture #(.DATA_W(DATA_W)) u_cap (
        .clk        (fast_clk),
        .rst        (fast_rst),
        .take       (win_hit),
        .word_in    (slow_data),
        .word_out   (fast_data),
        .word_valid (fast_valid)
    );

    // A pulse needs a counter that was already at the capture value.
    a_r5_pulse_after_count: assert property (@(posedge fast_clk) disable iff (fast_rst)
        fast_valid |-> ($past(win_count) == CNT_W'(CAPTURE_AT)));

    // An edge restarts the window, so no pulse directly follows one.
    a_r3_no_pulse_after_edge: assert property (@(posedge fast_clk) disable iff (fast_rst)
        en_rise |=> !fast_valid);

endmodule

// File: tb/tb_msmp_sampler.sv
`timescale 1ns/1ps
module tb_msmp_sampler;

    localparam int  DATA_W  = 8;
    localparam time SLOW_T  = 700;
    localparam int  WDOG    = 150000;

    logic              clk = 1'b0;
    logic              rst;
    logic [DATA_W-1:0] slow_data;
    logic              slow_en;
    logic [DATA_W-1:0] fast_data;
    logic              fast_valid;

    int unsigned checks = 0;
    int unsigned fails  = 0;
    int unsigned tx = 0;
    int unsigned rx = 0;
    int unsigned cycles = 0;
    logic [DATA_W-1:0] exp_word = '0;
    logic prev_valid = 1'b0;
    bit   done = 1'b0;

    always #5 clk = ~clk;

    msmp_sampler dut (
        .fast_clk   (clk),
        .fast_rst   (rst),
        .slow_data  (slow_data),
        .slow_en    (slow_en),
        .fast_data  (fast_data),
        .fast_valid (fast_valid)
    );

    // Each enable rising edge should give one pulse.
    function automatic int unsigned pulses_for(input int unsigned windows);
        return windows;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > WDOG) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, WDOG);
            finish_run();
        end
    end

    // Output monitor, sampled on the falling edge.
    always @(negedge clk) begin
        if (!rst) begin
            if (fast_valid) begin
                rx++;
                check(fast_data == exp_word, "R8 word", int'(fast_data), int'(exp_word));
                check(!prev_valid, "R6 width", int'(prev_valid), 0);
                check(slow_en == 1'b1, "R8 inside window", int'(slow_en), 1);
                check(rx <= tx, "R6 extra pulse", int'(rx), int'(tx));
            end
            prev_valid = fast_valid;
        end
    end

    task automatic window(input logic [DATA_W-1:0] word, input int len, input int gap);
        slow_data = word;
        exp_word  = word;
        slow_en   = 1'b1;
        tx++;
        repeat (len) #SLOW_T;
        slow_en = 1'b0;
        for (int g = 0; g < gap; g++) begin
            slow_data = DATA_W'($urandom);
            #SLOW_T;
        end
        check(rx == pulses_for(tx), "R6 count", int'(rx), int'(pulses_for(tx)));
        check(fast_data == word, "R7 hold", int'(fast_data), int'(word));
    endtask

    initial begin
        void'($urandom(32'd20240611));
        rst       = 1'b1;
        slow_en   = 1'b0;
        slow_data = '0;
        repeat (4) @(posedge clk);
        #2 rst = 1'b0;
        @(negedge clk);
        check(fast_data == '0, "R1 data", int'(fast_data), 0);
        check(fast_valid == 1'b0, "R1 valid", int'(fast_valid), 0);
        // No enable yet: the saturated counter must not fire (R1, R4).
        for (int k = 0; k < 3; k++) begin
            slow_data = DATA_W'($urandom);
            #SLOW_T;
        end
        check(rx == 0, "R1 no early capture", int'(rx), 0);
        check(fast_data == '0, "R1 data idle", int'(fast_data), 0);
        // Directed corners.
        window(8'hFF, 1, 1);
        window(8'h00, 1, 1);
        window(8'hA5, 3, 2);   // long enable: counter saturates (R4), one pulse (R3)
        window(8'h5A, 1, 1);   // back-to-back restart (R3)
        // Random windows.
        for (int w = 0; w < 40; w++) begin
            window(DATA_W'($urandom), 1 + int'($urandom % 2), 1 + int'($urandom % 3));
        end
        check(rx == tx, "R2 total pulses", int'(rx), int'(tx));
        finish_run();
    end

endmodule